// File: doc/BRIEF.md
# ECC Error Logger and Check-Bit Corruptor

This block sits next to the single-error-correct, double-error-detect logic of a DDR memory controller. The read-path decoder reports two kinds of failure: errors it repaired and errors it could not repair. For each kind the block keeps a separate record of the failing address, the syndrome and the 64-bit data word. Each kind also has a primary flag and an overflow flag. While any flag is set, a level interrupt stays high. Software clears flags by writing a mask to an acknowledge register, which is separate from the status register.

For self-test, software can arm a one-shot fault. The next write beat sent to the encoder then has its check byte XORed with a chosen 8-bit pattern, and the arm bit clears itself. The two low bits of the control register select the ECC mode. Events are logged only in the modes where ECC is active.

Top module: `ecc_err_log`

## Requirements
- R1: After reset the control register reads back the parameter `MODE_RST` in bits [1:0] and zero elsewhere. Every other register reads zero and `irq` is low.
- R2: Register byte offsets are as follows. Error group: control 0x00, uncorrectable address 0x08, uncorrectable status 0x0C, uncorrectable data bits [31:0] at 0x10 and [63:32] at 0x14, correctable address 0x18, correctable status 0x1C, correctable data [31:0] at 0x20 and [63:32] at 0x24. Interrupt group: status 0x40 and acknowledge 0x44. Unmapped offsets and the acknowledge register read zero.
- R3: A correctable event with logging active and interrupt status bit 3 clear sets bit 3. It also captures the address, the data word, and the syndrome in bits [15:8] of the correctable status register.
- R4: An uncorrectable event with logging active and bit 5 clear sets bit 5 and captures into the uncorrectable set in the same way. The correctable set is left unchanged.
- R5: A further event of a class whose primary flag is already set sets that class's overflow flag (bit 4 for correctable, bit 6 for uncorrectable) and leaves the first capture unchanged.
- R6: A correctable and an uncorrectable event in the same cycle load both capture sets and set both bits 3 and 5.
- R7: A write to the acknowledge register clears exactly the status bits set in the written value. `irq` is high whenever any of bits 3 to 6 is set and low otherwise.
- R8: With mode 0 or 2 in control bits [1:0], events change no status bit and no capture register. Modes 1 and 3 log events.
- R9: Control bit 8 arms corruption and bits [23:16] hold the pattern. While armed, `inj_mask` equals the pattern; otherwise it is zero. The first `wr_beat` while armed clears bit 8, so only one beat is corrupted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| ce_valid | input | 1 | Correctable error event |
| ce_addr | input | ADDR_W | Address of correctable error |
| ce_synd | input | 8 | Syndrome of correctable error |
| ce_data | input | 64 | Data word of correctable error |
| ue_valid | input | 1 | Uncorrectable error event |
| ue_addr | input | ADDR_W | Address of uncorrectable error |
| ue_synd | input | 8 | Syndrome of uncorrectable error |
| ue_data | input | 64 | Data word of uncorrectable error |
| wr_beat | input | 1 | A write beat passes through the encoder this cycle |
| inj_mask | output | 8 | XOR mask for the write check byte |
| irq | output | 1 | Level interrupt |

## Verification
Single correctable events check the field placement of address, syndrome and both data halves. They also confirm that the other class's capture set stays untouched. Back-to-back uncorrectable events with different addresses show whether the first capture survives and whether the overflow flag sets, as opposed to overwriting. Simultaneous events of both classes expose any priority between them. Partial acknowledge masks show whether clearing is per bit and whether the interrupt tracks the remaining bits. Finally, events in each disabled mode and in mode 3, plus two write beats after arming, separate correct mode decoding and a true one-shot from a mask that lingers.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;

    localparam int REG_AW = 7;
    localparam int REG_DW = 32;
    localparam int SYND_W = 8;
    localparam int DATA_W = 64;
    localparam int NCLS   = 2;
    localparam int CLS_CE = 0;
    localparam int CLS_UE = 1;

    // first-flag bit of class i is STAT_LSB + 2*i, overflow flag the next bit
    localparam int STAT_LSB = 3;

    localparam logic [REG_AW-1:0] OFS_CTRL    = 7'h00;
    localparam logic [REG_AW-1:0] OFS_UE_ADDR = 7'h08;
    localparam logic [REG_AW-1:0] OFS_UE_STAT = 7'h0C;
    localparam logic [REG_AW-1:0] OFS_UE_DLO  = 7'h10;
    localparam logic [REG_AW-1:0] OFS_UE_DHI  = 7'h14;
    localparam logic [REG_AW-1:0] OFS_CE_ADDR = 7'h18;
    localparam logic [REG_AW-1:0] OFS_CE_STAT = 7'h1C;
    localparam logic [REG_AW-1:0] OFS_CE_DLO  = 7'h20;
    localparam logic [REG_AW-1:0] OFS_CE_DHI  = 7'h24;
    localparam logic [REG_AW-1:0] OFS_ISTAT   = 7'h40;
    localparam logic [REG_AW-1:0] OFS_IACK    = 7'h44;

    localparam int CTRL_ARM_BIT = 8;
    localparam int CTRL_PAT_LSB = 16;

endpackage

// File: rtl/ecc_err_capture.sv
module ecc_err_capture #(
    parameter int ADDR_W = 32,
    parameter int SYND_W = 8,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              log_en,
    input  logic              evt_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [SYND_W-1:0] synd_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              ack_first_i,
    input  logic              ack_second_i,
    output logic              first_o,
    output logic              second_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [SYND_W-1:0] synd_o,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        logic              first;
        logic              second;
        logic [ADDR_W-1:0] addr;
        logic [SYND_W-1:0] synd;
        logic [DATA_W-1:0] data;
    } cap_t;

    cap_t cap_d, cap_q;
    logic hit;

    always_comb begin
        cap_d = cap_q;
        hit   = log_en & evt_i;
        if (ack_first_i)  cap_d.first  = 1'b0;
        if (ack_second_i) cap_d.second = 1'b0;
        if (hit) begin
            if (!cap_q.first) begin
                cap_d.first = 1'b1;
                cap_d.addr  = addr_i;
                cap_d.synd  = synd_i;
                cap_d.data  = data_i;
            end else begin
                cap_d.second = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign first_o  = cap_q.first;
    assign second_o = cap_q.second;
    assign addr_o   = cap_q.addr;
    assign synd_o   = cap_q.synd;
    assign data_o   = cap_q.data;

endmodule

// File: rtl/ecc_inj_ctrl.sv
module ecc_inj_ctrl
    import ecc_log_pkg::*;
#(
    parameter logic [1:0] MODE_RST = 2'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [REG_DW-1:0] wdata,
    input  logic              wr_beat_i,
    output logic [1:0]        mode_o,
    output logic              arm_o,
    output logic [SYND_W-1:0] pat_o,
    output logic [SYND_W-1:0] inj_mask_o
);

    typedef struct packed {
        logic [1:0]        mode;
        logic              arm;
        logic [SYND_W-1:0] pat;
    } ctl_t;

    localparam ctl_t CTL_RST = '{mode: MODE_RST, arm: 1'b0, pat: '0};

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_q.arm && wr_beat_i) ctl_d.arm = 1'b0;
        if (ctrl_we) begin
            ctl_d.mode = wdata[1:0];
            ctl_d.arm  = wdata[CTRL_ARM_BIT];
            ctl_d.pat  = wdata[CTRL_PAT_LSB +: SYND_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign mode_o     = ctl_q.mode;
    assign arm_o      = ctl_q.arm;
    assign pat_o      = ctl_q.pat;
    assign inj_mask_o = ctl_q.arm ? ctl_q.pat : '0;

endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
    import ecc_log_pkg::*;
#(
    parameter int         ADDR_W   = 32,
    parameter logic [1:0] MODE_RST = 2'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic              ce_valid,
    input  logic [ADDR_W-1:0] ce_addr,
    input  logic [SYND_W-1:0] ce_synd,
    input  logic [DATA_W-1:0] ce_data,
    input  logic              ue_valid,
    input  logic [ADDR_W-1:0] ue_addr,
    input  logic [SYND_W-1:0] ue_synd,
    input  logic [DATA_W-1:0] ue_data,
    input  logic              wr_beat,
    output logic [SYND_W-1:0] inj_mask,
    output logic              irq
);

    localparam int HALF_W = DATA_W / 2;

    logic              ctrl_we, ack_we, log_en, arm_q;
    logic [1:0]        mode_q;
    logic [SYND_W-1:0] pat_q;
    logic [REG_DW-1:0] int_stat;

    logic              evt_v   [NCLS];
    logic [ADDR_W-1:0] evt_a   [NCLS];
    logic [SYND_W-1:0] evt_s   [NCLS];
    logic [DATA_W-1:0] evt_d   [NCLS];
    logic              first_q [NCLS];
    logic              second_q[NCLS];
    logic [ADDR_W-1:0] cap_addr[NCLS];
    logic [SYND_W-1:0] cap_synd[NCLS];
    logic [DATA_W-1:0] cap_data[NCLS];

    assign ctrl_we = reg_we && (reg_addr == OFS_CTRL);
    assign ack_we  = reg_we && (reg_addr == OFS_IACK);
    assign log_en  = mode_q[0];

    assign evt_v[CLS_CE] = ce_valid;
    assign evt_a[CLS_CE] = ce_addr;
    assign evt_s[CLS_CE] = ce_synd;
    assign evt_d[CLS_CE] = ce_data;
    assign evt_v[CLS_UE] = ue_valid;
    assign evt_a[CLS_UE] = ue_addr;
    assign evt_s[CLS_UE] = ue_synd;
    assign evt_d[CLS_UE] = ue_data;

    ecc_inj_ctrl #(.MODE_RST(MODE_RST)) i_inj (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_we   (ctrl_we),
        .wdata     (reg_wdata),
        .wr_beat_i (wr_beat),
        .mode_o    (mode_q),
        .arm_o     (arm_q),
        .pat_o     (pat_q),
        .inj_mask_o(inj_mask)
    );

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        ecc_err_capture #(
            .ADDR_W(ADDR_W),
            .SYND_W(SYND_W),
            .DATA_W(DATA_W)
        ) i_cap (
            .clk         (clk),
            .rst_n       (rst_n),
            .log_en      (log_en),
            .evt_i       (evt_v[c]),
            .addr_i      (evt_a[c]),
            .synd_i      (evt_s[c]),
            .data_i      (evt_d[c]),
            .ack_first_i (ack_we & reg_wdata[STAT_LSB + 2*c]),
            .ack_second_i(ack_we & reg_wdata[STAT_LSB + 2*c + 1]),
            .first_o     (first_q[c]),
            .second_o    (second_q[c]),
            .addr_o      (cap_addr[c]),
            .synd_o      (cap_synd[c]),
            .data_o      (cap_data[c])
        );
    end

    always_comb begin
        int_stat = '0;
        for (int c = 0; c < NCLS; c++) begin
            int_stat[STAT_LSB + 2*c]     = first_q[c];
            int_stat[STAT_LSB + 2*c + 1] = second_q[c];
        end
    end

    assign irq = |int_stat;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_CTRL: begin
                reg_rdata[1:0]                      = mode_q;
                reg_rdata[CTRL_ARM_BIT]             = arm_q;
                reg_rdata[CTRL_PAT_LSB +: SYND_W]   = pat_q;
            end
            OFS_UE_ADDR: reg_rdata = REG_DW'(cap_addr[CLS_UE]);
            OFS_UE_STAT: reg_rdata[8 +: SYND_W] = cap_synd[CLS_UE];
            OFS_UE_DLO:  reg_rdata = cap_data[CLS_UE][HALF_W-1:0];
            OFS_UE_DHI:  reg_rdata = cap_data[CLS_UE][DATA_W-1:HALF_W];
            OFS_CE_ADDR: reg_rdata = REG_DW'(cap_addr[CLS_CE]);
            OFS_CE_STAT: reg_rdata[8 +: SYND_W] = cap_synd[CLS_CE];
            OFS_CE_DLO:  reg_rdata = cap_data[CLS_CE][HALF_W-1:0];
            OFS_CE_DHI:  reg_rdata = cap_data[CLS_CE][DATA_W-1:HALF_W];
            OFS_ISTAT:   reg_rdata = int_stat;
            default:     reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk
    import ecc_log_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_addr,
    input logic [REG_DW-1:0] reg_wdata,
    input logic              ce_valid,
    input logic              ue_valid,
    input logic              wr_beat,
    input logic              irq,
    input logic [1:0]        mode_q,
    input logic              arm_q,
    input logic [REG_DW-1:0] int_stat,
    input logic [ADDR_W-1:0] ce_cap_addr
);

    logic ack_w, ctl_w;
    assign ack_w = reg_we && (reg_addr == OFS_IACK);
    assign ctl_w = reg_we && (reg_addr == OFS_CTRL);

    a_r3_ce_logged: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[0] && ce_valid && !ack_w) |=> int_stat[3]);

    a_r4_ue_logged: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[0] && ue_valid && !ack_w) |=> int_stat[5]);

    a_r5_keep_first: assert property (@(posedge clk) disable iff (!rst_n)
        (int_stat[3] && !ack_w) |=> $stable(ce_cap_addr));

    a_r7_ack_all_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_w && (reg_wdata[6:3] == 4'hF) && !ce_valid && !ue_valid) |=> !irq);

    a_r8_disabled_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q[0] && !ack_w) |=> $stable(int_stat));

    a_r9_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q && wr_beat && !ctl_w) |=> !arm_q);

endmodule

bind ecc_err_log ecc_err_log_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .ce_valid   (ce_valid),
    .ue_valid   (ue_valid),
    .wr_beat    (wr_beat),
    .irq        (irq),
    .mode_q     (mode_q),
    .arm_q      (arm_q),
    .int_stat   (int_stat),
    .ce_cap_addr(cap_addr[0])
);

// File: tb/test_ecc_err_log.sv
module test_ecc_err_log;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ce_valid = 1'b0, ue_valid = 1'b0, wr_beat = 1'b0;
    logic [31:0] ce_addr = '0, ue_addr = '0;
    logic [7:0]  ce_synd = '0, ue_synd = '0;
    logic [63:0] ce_data = '0, ue_data = '0;
    logic [7:0]  inj_mask;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ecc_err_log #(.ADDR_W(32), .MODE_RST(2'd1)) i_ecc_err_log (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ce_valid(ce_valid), .ce_addr(ce_addr), .ce_synd(ce_synd), .ce_data(ce_data),
        .ue_valid(ue_valid), .ue_addr(ue_addr), .ue_synd(ue_synd), .ue_data(ue_data),
        .wr_beat(wr_beat), .inj_mask(inj_mask), .irq(irq)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic rdchk(input string req, input logic [6:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, $sformatf("reg 0x%0h", a), v, exp);
    endtask

    task automatic events(input bit ce, input bit ue);
        @(negedge clk);
        ce_valid = ce; ue_valid = ue;
        @(negedge clk);
        ce_valid = 1'b0; ue_valid = 1'b0;
    endtask

    task automatic t_reset;
        rdchk("R1", 7'h00, 32'h0000_0001);
        for (int a = 8; a <= 36; a += 4) rdchk("R1", 7'(a), 32'h0);
        rdchk("R1", 7'h40, 32'h0);
        chk("R1", "irq", {31'b0, irq}, 32'h0);
        chk("R1", "inj_mask", {24'b0, inj_mask}, 32'h0);
    endtask

    task automatic t_disabled;
        ce_addr = 32'hCAFE_0001; ce_synd = 8'h11; ce_data = 64'h1;
        ue_addr = 32'hCAFE_0002;
        wr(7'h00, 32'h2);
        events(1, 1);
        rdchk("R8", 7'h40, 32'h0);
        rdchk("R8", 7'h18, 32'h0);
        rdchk("R8", 7'h08, 32'h0);
        chk("R8", "irq mode2", {31'b0, irq}, 32'h0);
        wr(7'h00, 32'h0);
        events(1, 0);
        rdchk("R8", 7'h40, 32'h0);
        rdchk("R8", 7'h1C, 32'h0);
        wr(7'h00, 32'h3);
        events(1, 0);
        rdchk("R8", 7'h40, 32'h8);
        wr(7'h44, 32'h8);
        wr(7'h00, 32'h1);
    endtask

    task automatic t_ce;
        ce_addr = 32'h1234_5678; ce_synd = 8'hA5; ce_data = 64'hDEAD_BEEF_0123_4567;
        events(1, 0);
        chk("R7", "irq after ce", {31'b0, irq}, 32'h1);
        rdchk("R3", 7'h40, 32'h8);
        rdchk("R3", 7'h18, 32'h1234_5678);
        rdchk("R3", 7'h1C, 32'h0000_A500);
        rdchk("R3", 7'h20, 32'h0123_4567);
        rdchk("R3", 7'h24, 32'hDEAD_BEEF);
        rdchk("R4", 7'h08, 32'h0);
        rdchk("R2", 7'h44, 32'h0);
        rdchk("R2", 7'h30, 32'h0);
        wr(7'h44, 32'h8);
        rdchk("R7", 7'h40, 32'h0);
        chk("R7", "irq after ack", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_ue_double;
        ue_addr = 32'h0000_A100; ue_synd = 8'h3C; ue_data = 64'h1111_2222_3333_4444;
        events(0, 1);
        ue_addr = 32'h0000_A200; ue_synd = 8'hC3; ue_data = 64'h5;
        events(0, 1);
        rdchk("R5", 7'h40, 32'h60);
        rdchk("R5", 7'h08, 32'h0000_A100);
        rdchk("R4", 7'h0C, 32'h0000_3C00);
        rdchk("R4", 7'h10, 32'h3333_4444);
        rdchk("R4", 7'h14, 32'h1111_2222);
        rdchk("R4", 7'h18, 32'h1234_5678);
        wr(7'h44, 32'h20);
        rdchk("R7", 7'h40, 32'h40);
        chk("R7", "irq partial", {31'b0, irq}, 32'h1);
        wr(7'h44, 32'h40);
        chk("R7", "irq cleared", {31'b0, irq}, 32'h0);
        ce_addr = 32'h0BAD_0001; ce_synd = 8'h01;
        events(1, 0);
        ce_addr = 32'h0BAD_0002; ce_synd = 8'h02;
        events(1, 0);
        rdchk("R5", 7'h40, 32'h18);
        rdchk("R5", 7'h18, 32'h0BAD_0001);
        rdchk("R5", 7'h1C, 32'h0000_0100);
        wr(7'h44, 32'h18);
    endtask

    task automatic t_simul;
        ce_addr = 32'h00C0_FFEE; ce_synd = 8'h77; ce_data = 64'h0;
        ue_addr = 32'h00BE_EF00; ue_synd = 8'h88; ue_data = 64'hFFFF_FFFF_0000_0000;
        events(1, 1);
        rdchk("R6", 7'h40, 32'h28);
        rdchk("R6", 7'h18, 32'h00C0_FFEE);
        rdchk("R6", 7'h08, 32'h00BE_EF00);
        rdchk("R6", 7'h14, 32'hFFFF_FFFF);
        wr(7'h44, 32'h28);
        rdchk("R7", 7'h40, 32'h0);
    endtask

    task automatic t_inject;
        logic [31:0] v;
        wr(7'h00, 32'h005A_0101);
        rdchk("R9", 7'h00, 32'h005A_0101);
        chk("R9", "mask armed", {24'b0, inj_mask}, 32'h5A);
        @(negedge clk); wr_beat = 1'b1;
        @(negedge clk); wr_beat = 1'b0;
        chk("R9", "mask after beat", {24'b0, inj_mask}, 32'h0);
        rd(7'h00, v);
        chk("R9", "arm self-clear", v, 32'h005A_0001);
        @(negedge clk); wr_beat = 1'b1;
        #1;
        chk("R9", "mask second beat", {24'b0, inj_mask}, 32'h0);
        @(negedge clk); wr_beat = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_ce();
        t_ue_double();
        t_simul();
        t_inject();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule